// File: doc/BRIEF.md
# Sampling Clock Controller Register Block

This block holds the configuration and status registers of a sampling clock controller that sits beside an SD host running in its fastest bus mode. Software reaches it over a simple request/acknowledge register bus. It controls whether the delay-tap line is enabled. It selects a tap position and a fixed tap, chooses the tuned sampling clock and arms automatic retuning. It also reports how many taps the delay line has. The delay line and the card data path live elsewhere and only consume the field outputs.

A bus access is handled by a three-state machine. `BUS_IDLE` waits for a request. When a request arrives, the transition *accept-write* goes to `BUS_WACK` and *accept-read* goes to `BUS_RACK`. Each acknowledge state lasts exactly one cycle and takes the *complete* transition back to `BUS_IDLE`. A write takes effect at the accepting edge. Read data is captured at that same edge and appears on the data output only during `BUS_RACK`. Register offsets are multiplied by a power of two set by `BUS_SHIFT` to form bus addresses.

A retuning error pulse from the delay-line monitor sets a sticky flag. Software clears the flag with a write. The interrupt-style error output shows the flag only while auto-retuning is armed.

Top module: `scc_regs`

## Requirements
- R1: A request seen in `BUS_IDLE` is accepted. `ack` is high for exactly the next cycle. A request made while `ack` is high is ignored, and no write from it takes effect.
- R2: A register at offset O (delay control 0x0, tap position 0x2, fixed tap 0x4, clock select 0x6, retune control 0x8, retune status 0xA) sits at bus address O << `BUS_SHIFT`. An address whose low `BUS_SHIFT` bits are not zero, or whose offset is not listed, reads as 0. A write to such an address changes nothing.
- R3: Delay control bit 0 is a read/write tap enable that drives `tap_en`. Bits 23:16 always read `TAP_COUNT` (8), whatever was written. All other bits read 0.
- R4: Bits 7:0 of the tap position register are read/write and drive `tap_sel`. Bits 7:0 of the fixed-tap register are read/write and drive `fix_tap`. Upper bits read 0.
- R5: Clock select bit 0 drives `clk_tuned`. Retune control bit 0 drives `rt_en`. Both are read/write.
- R6: When `err_in` is high at an edge, the sticky error flag is set at that edge. The flag reads back as bit 2 of the retune status register and stays set until it is cleared.
- R7: A write to retune status with bit 2 = 0 clears the flag. A write with bit 2 = 1 leaves the flag as it was. If `err_in` is high at the edge where a clearing write is accepted, the flag stays set.
- R8: `rt_err_irq` is high exactly when the error flag is set and `rt_en` is 1. The flag keeps its value while `rt_en` is 0.
- R9: A synchronous reset returns the machine to `BUS_IDLE`. It clears every writable field and the error flag, drives `ack` low and drives `rdata` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Bus request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Bus byte address |
| wdata | input | DATA_W | Write data |
| ack | output | 1 | Access acknowledge, one cycle |
| rdata | output | DATA_W | Read data, valid while ack follows a read, else 0 |
| err_in | input | 1 | Retuning error pulse from the delay-line monitor |
| tap_en | output | 1 | Delay-tap enable |
| tap_sel | output | TAP_W | Selected tap position |
| fix_tap | output | TAP_W | Fixed tap position |
| clk_tuned | output | 1 | Use the tuned sampling clock |
| rt_en | output | 1 | Auto-retuning enable |
| rt_err_irq | output | 1 | Retuning error indication, gated by rt_en |

## Verification
The hardest situation to reach is the race between a clearing write to the retune status register and a fresh `err_in` pulse at the same edge. The outcome then depends on the relative timing of two independent inputs. The bench drives `err_in` high in exactly the cycle whose edge accepts the clearing write. It then reads the status back and expects bit 2 to still be set. A second hard case is a request held high across the acknowledge cycle. The bench keeps `req` asserted for two cycles with a different write value and confirms that only the first access lands.

// File: rtl/scc_pkg.sv
package scc_pkg;

    // bus access machine
    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_WACK = 2'd1,
        BUS_RACK = 2'd2
    } bus_state_e;

    // decoded register selection
    typedef enum logic [2:0] {
        RSEL_DLY  = 3'd0,
        RSEL_TAP  = 3'd1,
        RSEL_FIX  = 3'd2,
        RSEL_CKS  = 3'd3,
        RSEL_RTC  = 3'd4,
        RSEL_RTQ  = 3'd5,
        RSEL_NONE = 3'd6
    } reg_sel_e;

    // register offsets, before scaling by the bus shift
    localparam int OFS_DLY = 'h000;
    localparam int OFS_TAP = 'h002;
    localparam int OFS_FIX = 'h004;
    localparam int OFS_CKS = 'h006;
    localparam int OFS_RTC = 'h008;
    localparam int OFS_RTQ = 'h00A;

    // field positions
    localparam int CNT_LSB = 16;
    localparam int CNT_W   = 8;
    localparam int ERR_BIT = 2;

endpackage

// File: rtl/scc_addr_decode.sv
module scc_addr_decode
    import scc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BUS_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int OFS_W = ADDR_W - BUS_SHIFT;

    logic             aligned;
    logic [OFS_W-1:0] ofs;

    generate
        if (BUS_SHIFT == 0) begin : g_noshift
            assign aligned = 1'b1;
        end else begin : g_shift
            assign aligned = (addr[BUS_SHIFT-1:0] == '0);
        end
    endgenerate

    assign ofs = addr[ADDR_W-1:BUS_SHIFT];

    always_comb begin
        sel = RSEL_NONE;
        if (aligned) begin
            if      (ofs == OFS_W'(OFS_DLY)) sel = RSEL_DLY;
            else if (ofs == OFS_W'(OFS_TAP)) sel = RSEL_TAP;
            else if (ofs == OFS_W'(OFS_FIX)) sel = RSEL_FIX;
            else if (ofs == OFS_W'(OFS_CKS)) sel = RSEL_CKS;
            else if (ofs == OFS_W'(OFS_RTC)) sel = RSEL_RTC;
            else if (ofs == OFS_W'(OFS_RTQ)) sel = RSEL_RTQ;
        end
    end
endmodule

// File: rtl/scc_bus_fsm.sv
module scc_bus_fsm
    import scc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       we,
    output bus_state_e state_o,
    output logic       wr_stb,
    output logic       rd_stb,
    output logic       ack
);
    bus_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= BUS_IDLE;
        else     state_q <= state_d;
    end

    // transitions: accept-write, accept-read, complete
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req) state_d = we ? BUS_WACK : BUS_RACK;
            BUS_WACK: state_d = BUS_IDLE;
            BUS_RACK: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_stb = 1'b0;
        rd_stb = 1'b0;
        ack    = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                wr_stb = req & we;
                rd_stb = req & ~we;
            end
            BUS_WACK: ack = 1'b1;
            BUS_RACK: ack = 1'b1;
            default:  ack = 1'b0;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/scc_err_flag.sv
module scc_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic err_in,
    input  logic clr,
    output logic flag
);
    logic flag_q;

    // a new error wins over a simultaneous clear
    always_ff @(posedge clk) begin
        if (rst)         flag_q <= 1'b0;
        else if (err_in) flag_q <= 1'b1;
        else if (clr)    flag_q <= 1'b0;
    end

    assign flag = flag_q;
endmodule

// File: rtl/scc_regs.sv
module scc_regs
    import scc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int BUS_SHIFT = 2,
    parameter int TAP_W     = 8,
    parameter int TAP_COUNT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    input  logic              err_in,
    output logic              tap_en,
    output logic [TAP_W-1:0]  tap_sel,
    output logic [TAP_W-1:0]  fix_tap,
    output logic              clk_tuned,
    output logic              rt_en,
    output logic              rt_err_irq
);
    bus_state_e        state_q;
    logic              wr_stb, rd_stb, bus_idle;
    reg_sel_e          sel;
    logic              tap_en_q, cks_q, rte_q, err_flag_q, err_clr;
    logic [TAP_W-1:0]  tap_q, fix_q;
    logic [DATA_W-1:0] rd_d, rd_q;
    logic              unused_wbits;

    assign unused_wbits = ^wdata;

    scc_bus_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .we      (we),
        .state_o (state_q),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .ack     (ack)
    );

    scc_addr_decode #(
        .ADDR_W    (ADDR_W),
        .BUS_SHIFT (BUS_SHIFT)
    ) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    assign err_clr = wr_stb && (sel == RSEL_RTQ) && !wdata[ERR_BIT];

    scc_err_flag u_err (
        .clk    (clk),
        .rst    (rst),
        .err_in (err_in),
        .clr    (err_clr),
        .flag   (err_flag_q)
    );

    // writable fields
    always_ff @(posedge clk) begin
        if (rst) begin
            tap_en_q <= 1'b0;
            tap_q    <= '0;
            fix_q    <= '0;
            cks_q    <= 1'b0;
            rte_q    <= 1'b0;
        end else if (wr_stb) begin
            unique case (sel)
                RSEL_DLY: tap_en_q <= wdata[0];
                RSEL_TAP: tap_q    <= wdata[TAP_W-1:0];
                RSEL_FIX: fix_q    <= wdata[TAP_W-1:0];
                RSEL_CKS: cks_q    <= wdata[0];
                RSEL_RTC: rte_q    <= wdata[0];
                default:  ;
            endcase
        end
    end

    // read mux
    always_comb begin
        rd_d = '0;
        unique case (sel)
            RSEL_DLY: begin
                rd_d[0]                = tap_en_q;
                rd_d[CNT_LSB +: CNT_W] = CNT_W'(TAP_COUNT);
            end
            RSEL_TAP: rd_d[TAP_W-1:0] = tap_q;
            RSEL_FIX: rd_d[TAP_W-1:0] = fix_q;
            RSEL_CKS: rd_d[0]         = cks_q;
            RSEL_RTC: rd_d[0]         = rte_q;
            RSEL_RTQ: rd_d[ERR_BIT]   = err_flag_q;
            default:  rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_q <= '0;
        else if (rd_stb) rd_q <= rd_d;
    end

    assign bus_idle   = (state_q == BUS_IDLE);
    assign rdata      = (state_q == BUS_RACK) ? rd_q : '0;
    assign tap_en     = tap_en_q;
    assign tap_sel    = tap_q;
    assign fix_tap    = fix_q;
    assign clk_tuned  = cks_q;
    assign rt_en      = rte_q;
    assign rt_err_irq = rte_q & err_flag_q;
endmodule

// File: rtl/scc_regs_chk.sv
module scc_regs_chk #(
    parameter int TAP_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req,
    input logic             ack,
    input logic             bus_idle,
    input logic             wr_stb,
    input logic             err_in,
    input logic             flag,
    input logic             rt_en,
    input logic             rt_err_irq,
    input logic [TAP_W-1:0] tap_sel
);
    // R1
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R1
    accept_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (req && bus_idle) |=> ack);

    // R6
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        err_in |=> flag);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        rt_err_irq |-> (rt_en && flag));

    // R4
    tap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(tap_sel));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!ack && !flag && tap_sel == '0 && !rt_err_irq));
endmodule

bind scc_regs scc_regs_chk #(.TAP_W(TAP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .ack        (ack),
    .bus_idle   (bus_idle),
    .wr_stb     (wr_stb),
    .err_in     (err_in),
    .flag       (err_flag_q),
    .rt_en      (rt_en),
    .rt_err_irq (rt_err_irq),
    .tap_sel    (tap_sel)
);

// File: tb/sim_scc_regs.sv
module sim_scc_regs;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SH = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          err_in = 1'b0;
    logic          ack, tap_en, clk_tuned, rt_en, rt_err_irq;
    logic [DW-1:0] rdata;
    logic [7:0]    tap_sel, fix_tap;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;  // 125 MHz

    scc_regs #(.ADDR_W(AW), .DATA_W(DW), .BUS_SHIFT(SH)) u0 (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .ack(ack), .rdata(rdata), .err_in(err_in), .tap_en(tap_en),
        .tap_sel(tap_sel), .fix_tap(fix_tap), .clk_tuned(clk_tuned),
        .rt_en(rt_en), .rt_err_irq(rt_err_irq)
    );

    // ---------------- behavioural reference model ----------------
    int  m_phase = 0;  // 0 waiting, 1 write ack, 2 read ack
    bit  m_started = 0;
    bit  m_tap_en, m_cks, m_rte, m_flag;
    int  m_tap, m_fix;
    longint m_rd;

    function automatic int reg_index(input int a);
        if (a % (1 << SH) != 0) return -1;
        case (a >> SH)
            'h0: return 0;
            'h2: return 1;
            'h4: return 2;
            'h6: return 3;
            'h8: return 4;
            'hA: return 5;
            default: return -1;
        endcase
    endfunction

    function automatic longint model_read(input int idx);
        case (idx)
            0: return (longint'(8) << 16) | longint'(m_tap_en);
            1: return longint'(m_tap);
            2: return longint'(m_fix);
            3: return longint'(m_cks);
            4: return longint'(m_rte);
            5: return m_flag ? 4 : 0;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_started = 1;
            m_phase = 0; m_tap_en = 0; m_cks = 0; m_rte = 0; m_flag = 0;
            m_tap = 0; m_fix = 0; m_rd = 0;
        end else begin
            bit clr;
            int idx;
            clr = 0;
            idx = reg_index(int'(addr));
            if (m_phase == 0 && req) begin
                if (we) begin
                    case (idx)
                        0: m_tap_en = wdata[0];
                        1: m_tap = int'(wdata & 32'hFF);
                        2: m_fix = int'(wdata & 32'hFF);
                        3: m_cks = wdata[0];
                        4: m_rte = wdata[0];
                        5: clr = !wdata[2];
                        default: ;
                    endcase
                    m_phase = 1;
                end else begin
                    m_rd = model_read(idx);
                    m_phase = 2;
                end
            end else begin
                m_phase = 0;
            end
            if (err_in) m_flag = 1;
            else if (clr) m_flag = 0;
        end
    end

    task automatic cmp(input string tag, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (m_started) begin
            cmp("R1 ack", longint'(ack), longint'(m_phase != 0));
            cmp("R2/R3 rdata", longint'(rdata), (m_phase == 2) ? m_rd : 0);
            cmp("R3 tap_en", longint'(tap_en), longint'(m_tap_en));
            cmp("R4 tap_sel", longint'(tap_sel), longint'(m_tap));
            cmp("R4 fix_tap", longint'(fix_tap), longint'(m_fix));
            cmp("R5 clk_tuned", longint'(clk_tuned), longint'(m_cks));
            cmp("R5 rt_en", longint'(rt_en), longint'(m_rte));
            cmp("R8 rt_err_irq", longint'(rt_err_irq), longint'(m_rte && m_flag));
        end
    end

    // ---------------- directed tasks ----------------
    task automatic bus_wr(input int a, input longint d);
        @(negedge clk);
        req = 1; we = 1; addr = AW'(a); wdata = DW'(d);
        @(negedge clk);
        req = 0; we = 0;
    endtask

    task automatic bus_rd(input int a, input longint exp, input string tag);
        @(negedge clk);
        req = 1; we = 0; addr = AW'(a);
        @(negedge clk);
        req = 0;
        cmp(tag, longint'(rdata), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R9 reset state
        cmp("R9 ack", longint'(ack), 0);
        cmp("R9 rdata", longint'(rdata), 0);
        cmp("R9 tap_sel", longint'(tap_sel), 0);

        bus_rd('h00, 'h0008_0000, "R3 count");
        bus_wr('h00, 'hFFFF_FFFF);
        bus_rd('h00, 'h0008_0001, "R3 count ro");
        bus_wr('h08, 'h1A5);
        bus_rd('h08, 'hA5, "R4 tap");
        bus_wr('h10, 'h3C);
        bus_rd('h10, 'h3C, "R4 fix");
        bus_wr('h18, 1);
        bus_rd('h18, 1, "R5 cks");
        // R2 misaligned write ignored, unlisted offset reads 0
        bus_wr('h09, 'h77);
        bus_rd('h08, 'hA5, "R2 misaligned write");
        bus_rd('h09, 0, "R2 misaligned read");
        bus_rd('h30, 0, "R2 unlisted read");
        // R6 error sets flag, R8 hidden while rt_en low
        @(negedge clk); err_in = 1;
        @(negedge clk); err_in = 0;
        cmp("R8 gated", longint'(rt_err_irq), 0);
        bus_rd('h28, 4, "R6 sticky");
        bus_wr('h20, 1);
        @(negedge clk);
        cmp("R8 irq", longint'(rt_err_irq), 1);
        // R7 bit2=1 keeps, bit2=0 clears
        bus_wr('h28, 4);
        bus_rd('h28, 4, "R7 keep");
        bus_wr('h28, 0);
        bus_rd('h28, 0, "R7 clear");
        // R7 error at the clearing edge wins
        @(negedge clk); err_in = 1;
        @(negedge clk); err_in = 0;
        @(negedge clk);
        req = 1; we = 1; addr = 'h28; wdata = 0; err_in = 1;
        @(negedge clk);
        req = 0; we = 0; err_in = 0;
        bus_rd('h28, 4, "R7 race");
        // R1 request held across ack: second write ignored
        @(negedge clk);
        req = 1; we = 1; addr = 'h08; wdata = 'h11;
        @(negedge clk);
        wdata = 'h22;
        @(negedge clk);
        req = 0; we = 0;
        bus_rd('h08, 'h11, "R1 held req");
        // mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            req    = ($urandom % 3) != 0;
            we     = $urandom % 2;
            addr   = AW'(($urandom % 12) * 4 + (($urandom % 8 == 0) ? 1 : 0));
            wdata  = DW'($urandom);
            err_in = ($urandom % 10) == 0;
        end
        @(negedge clk);
        req = 0; err_in = 0;
        // R9 mid-run reset
        rst = 1;
        @(negedge clk);
        rst = 0;
        cmp("R9 rt_en", longint'(rt_en), 0);
        bus_rd('h28, 0, "R9 flag");
        bus_rd('h00, 'h0008_0000, "R9 dly");
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule